// File: doc/BRIEF.md
# Initiator Data Parity Error Reporter

This block watches the data phases of bus transfers that the device itself started and checks their even parity. Each qualified data phase is captured when both ready signals are high. The parity bit is compared one clock later, because the bus delivers it in the following cycle. A mismatch can do three things. It can pulse an active-low error output. It can set a sticky "data parity detected" flag. It can set a sticky "detected parity error" flag.

The parity-error-response enable, taken from the command register, gates both the error pulse and the "detected" flag. The second flag records errors seen on read transfers and is independent of that enable. Software clears both flags by writing ones to their bit positions in the status register. Address parity, system-error signalling and target-side checking are not part of this block.

Top module: `parity_reporter`

## Requirements
- R1: While `rst` is high at a clock edge, after that edge `perr_n` is 1 and `stat_dpd` and `stat_dpe` are 0.
- R2: Parity is even. A phase is in error when the XOR of the 32 bits of `ad_in`, the 4 bits of `be_in` (raw line values) and the `par_in` value sampled one clock later is 1. A phase with correct parity changes no output.
- R3: A phase is checked only when `own_xfer` is 1 during the data phase. Errors on other phases change no output.
- R4: A phase is checked only when `init_rdy` and `tgt_rdy` are both 1 in the same cycle. Otherwise it changes no output.
- R5: With `resp_en` at 1, an erroneous phase in cycle k drives `perr_n` low during cycle k+2 only, and it is high again in cycle k+3 unless another error follows.
- R6: With `resp_en` at 0 during cycle k+1, `perr_n` stays high and `stat_dpd` is not set.
- R7: `stat_dpd` (status bit 8) becomes 1 in cycle k+2 after an erroneous phase when `resp_en` is 1.
- R8: `stat_dpe` (status bit 15) becomes 1 in cycle k+2 after an erroneous phase with `xfer_read` at 1, whatever `resp_en` is. An erroneous write phase leaves it unchanged.
- R9: Both flags are sticky. A cycle with `stat_wr` at 1 clears `stat_dpd` when `stat_wdata[8]` is 1 and clears `stat_dpe` when `stat_wdata[15]` is 1. Zero bits leave a flag unchanged, and a set in the same cycle wins over a clear.
- R10: Back-to-back data phases are each checked on their own in consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| ad_in | input | 32 | Address/data lines during a data phase |
| be_in | input | 4 | Byte-enable lines as seen on the bus |
| par_in | input | 1 | Parity line, valid one clock after its data phase |
| init_rdy | input | 1 | Initiator ready (active high) |
| tgt_rdy | input | 1 | Target ready (active high) |
| own_xfer | input | 1 | This device is the initiator of the current transfer |
| xfer_read | input | 1 | Current transfer is a read |
| resp_en | input | 1 | Parity error response enable (command bit 6) |
| stat_wr | input | 1 | Status register write strobe |
| stat_wdata | input | 16 | Status write data, ones clear bits 8 and 15 |
| perr_n | output | 1 | Active-low data parity error pulse |
| stat_dpd | output | 1 | Sticky data-parity-detected flag (status bit 8) |
| stat_dpe | output | 1 | Sticky detected-parity-error flag (status bit 15) |

## Verification
A data phase driven in cycle k is captured at the edge that ends k. Its parity is driven in cycle k+1 and compared at the edge that ends k+1. So `perr_n` and both flags change at that edge and are first observable in cycle k+2. A status write in cycle j takes effect at the edge that ends j. The bench drives inputs on falling edges and samples outputs in the middle of the cycle where each result is due. For the one-clock pulse it samples one cycle later as well, and for back-to-back phases it walks cycle by cycle.

// File: rtl/pdr_pkg.sv
package pdr_pkg;

    // Bit positions of the sticky flags inside the status register
    localparam int DPD_BIT = 8;
    localparam int DPE_BIT = 15;

    // One captured data phase, waiting for its parity bit
    typedef struct packed {
        logic valid;     // phase was qualified and belongs to us
        logic is_read;   // transfer direction
        logic calc_par;  // XOR of data and byte-enable lines
    } phase_t;

    // Even parity: data XOR enables XOR parity bit must be zero
    function automatic logic phase_err(input phase_t p, input logic par);
        return p.valid & (p.calc_par ^ par);
    endfunction

endpackage

// File: rtl/pdr_capture.sv
module pdr_capture
    import pdr_pkg::*;
#(
    parameter int AD_W = 32,
    parameter int BE_W = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [AD_W-1:0] ad,
    input  logic [BE_W-1:0] be,
    input  logic            own,
    input  logic            irdy,
    input  logic            trdy,
    input  logic            is_read,
    output phase_t          cap
);

    localparam int LINES = AD_W + BE_W;

    logic [LINES-1:0] lines;
    assign lines = {ad, be};

    always_ff @(posedge clk) begin
        if (rst) begin
            cap <= '0;
        end else begin
            cap.valid    <= own & irdy & trdy;
            cap.is_read  <= is_read;
            cap.calc_par <= ^lines;
        end
    end

    // R3: a captured phase must come from a transfer we initiated
    a_r3_valid_needs_initiator: assert property (@(posedge clk) disable iff (rst)
        cap.valid |-> $past(own));

    // R4: a captured phase must have had both ready signals high
    a_r4_valid_needs_ready: assert property (@(posedge clk) disable iff (rst)
        cap.valid |-> $past(irdy && trdy));

endmodule

// File: rtl/pdr_status.sv
module pdr_status
    import pdr_pkg::*;
#(
    parameter int CSR_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             set_dpd,
    input  logic             set_dpe,
    input  logic             wr,
    input  logic [CSR_W-1:0] wdata,
    output logic             dpd,
    output logic             dpe
);

    logic clr_dpd, clr_dpe;
    assign clr_dpd = wr & wdata[DPD_BIT];
    assign clr_dpe = wr & wdata[DPE_BIT];

    // Set has priority over a write-one-to-clear in the same cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            dpd <= 1'b0;
            dpe <= 1'b0;
        end else begin
            dpd <= set_dpd | (dpd & ~clr_dpd);
            dpe <= set_dpe | (dpe & ~clr_dpe);
        end
    end

    // R9: flags hold unless a one is written to their bit
    a_r9_dpd_sticky: assert property (@(posedge clk) disable iff (rst)
        (dpd && !(wr && wdata[DPD_BIT])) |=> dpd);

    a_r9_dpe_sticky: assert property (@(posedge clk) disable iff (rst)
        (dpe && !(wr && wdata[DPE_BIT])) |=> dpe);

endmodule

// File: rtl/parity_reporter.sv
module parity_reporter
    import pdr_pkg::*;
#(
    parameter int AD_W  = 32,
    parameter int BE_W  = 4,
    parameter int CSR_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [AD_W-1:0]  ad_in,
    input  logic [BE_W-1:0]  be_in,
    input  logic             par_in,
    input  logic             init_rdy,
    input  logic             tgt_rdy,
    input  logic             own_xfer,
    input  logic             xfer_read,
    input  logic             resp_en,
    input  logic             stat_wr,
    input  logic [CSR_W-1:0] stat_wdata,
    output logic             perr_n,
    output logic             stat_dpd,
    output logic             stat_dpe
);

    phase_t cap;
    logic   err;
    logic   perr_q;

    pdr_capture #(.AD_W(AD_W), .BE_W(BE_W)) u_capture (
        .clk     (clk),
        .rst     (rst),
        .ad      (ad_in),
        .be      (be_in),
        .own     (own_xfer),
        .irdy    (init_rdy),
        .trdy    (tgt_rdy),
        .is_read (xfer_read),
        .cap     (cap)
    );

    // Parity arrives one clock after its phase: compare now
    assign err = phase_err(cap, par_in);

    always_ff @(posedge clk) begin
        if (rst) perr_q <= 1'b1;
        else     perr_q <= ~(err & resp_en);
    end
    assign perr_n = perr_q;

    pdr_status #(.CSR_W(CSR_W)) u_status (
        .clk     (clk),
        .rst     (rst),
        .set_dpd (err & resp_en),
        .set_dpe (err & cap.is_read),
        .wr      (stat_wr),
        .wdata   (stat_wdata),
        .dpd     (stat_dpd),
        .dpe     (stat_dpe)
    );

    // R1: reset leaves the outputs idle
    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (perr_n && !stat_dpd && !stat_dpe));

    // R6: the error pulse only appears with response enabled
    a_r6_perr_needs_enable: assert property (@(posedge clk) disable iff (rst)
        !perr_n |-> $past(resp_en));

    // R7: the detected flag rises together with an error pulse
    a_r7_dpd_with_perr: assert property (@(posedge clk) disable iff (rst)
        $rose(stat_dpd) |-> !perr_n);

    // R8: the read-error flag rises only after a read phase
    a_r8_dpe_on_read: assert property (@(posedge clk) disable iff (rst)
        $rose(stat_dpe) |-> $past(cap.is_read));

endmodule

// File: tb/sim_parity_reporter.sv
module sim_parity_reporter;

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] ad_in;
    logic [3:0]  be_in;
    logic        par_in, init_rdy, tgt_rdy, own_xfer, xfer_read, resp_en, stat_wr;
    logic [15:0] stat_wdata;
    logic        perr_n, stat_dpd, stat_dpe;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    parity_reporter u0 (
        .clk(clk), .rst(rst), .ad_in(ad_in), .be_in(be_in), .par_in(par_in),
        .init_rdy(init_rdy), .tgt_rdy(tgt_rdy), .own_xfer(own_xfer),
        .xfer_read(xfer_read), .resp_en(resp_en), .stat_wr(stat_wr),
        .stat_wdata(stat_wdata), .perr_n(perr_n), .stat_dpd(stat_dpd),
        .stat_dpe(stat_dpe)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic idle_bus();
        init_rdy = 0; tgt_rdy = 0; own_xfer = 0; xfer_read = 0;
        ad_in = '0; be_in = '0; par_in = 0; stat_wr = 0; stat_wdata = '0;
    endtask

    // Data phase in cycle k, parity in k+1, returns mid-cycle k+2
    task automatic run_phase(input logic [31:0] a, input logic [3:0] b,
                             input logic own, input logic rd, input logic ir,
                             input logic tr, input logic flip, input logic clr);
        @(negedge clk);
        ad_in = a; be_in = b; own_xfer = own; xfer_read = rd;
        init_rdy = ir; tgt_rdy = tr;
        @(negedge clk);
        idle_bus();
        par_in = (^{a, b}) ^ flip;
        if (clr) begin stat_wr = 1; stat_wdata = 16'h8100; end
        @(negedge clk);
        idle_bus();
    endtask

    task automatic write_status(input logic [15:0] d);
        @(negedge clk);
        stat_wr = 1; stat_wdata = d;
        @(negedge clk);
        stat_wr = 0; stat_wdata = '0;
    endtask

    task automatic t_reset();
        rst = 1; resp_en = 0; idle_bus();
        repeat (3) @(negedge clk);
        chk("R1 perr_n", perr_n, 1'b1);
        chk("R1 dpd", stat_dpd, 1'b0);
        chk("R1 dpe", stat_dpe, 1'b0);
        rst = 0;
    endtask

    task automatic t_good();
        resp_en = 1;
        run_phase(32'hDEAD_BEEF, 4'h0, 1, 1, 1, 1, 0, 0);
        chk("R2 good read perr_n", perr_n, 1'b1);
        run_phase(32'h0000_0001, 4'hE, 1, 0, 1, 1, 0, 0);
        chk("R2 good write perr_n", perr_n, 1'b1);
        run_phase(32'hFFFF_FFFF, 4'h7, 1, 1, 1, 1, 0, 0);
        chk("R2 good dpd", stat_dpd, 1'b0);
        chk("R2 good dpe", stat_dpe, 1'b0);
    endtask

    task automatic t_bad_read();
        resp_en = 1;
        run_phase(32'h1234_5678, 4'h3, 1, 1, 1, 1, 1, 0);
        chk("R5 perr_n low at k+2", perr_n, 1'b0);
        chk("R7 dpd set", stat_dpd, 1'b1);
        chk("R8 dpe set on read", stat_dpe, 1'b1);
        @(negedge clk);
        chk("R5 perr_n high at k+3", perr_n, 1'b1);
        write_status(16'h0100);
        chk("R9 dpd cleared", stat_dpd, 1'b0);
        chk("R9 dpe kept", stat_dpe, 1'b1);
        write_status(16'h0000);
        chk("R9 zero write keeps dpe", stat_dpe, 1'b1);
        write_status(16'h8000);
        chk("R9 dpe cleared", stat_dpe, 1'b0);
    endtask

    task automatic t_bad_write();
        resp_en = 1;
        run_phase(32'hA5A5_0F0F, 4'h9, 1, 0, 1, 1, 1, 0);
        chk("R5 write error perr_n", perr_n, 1'b0);
        chk("R7 write error dpd", stat_dpd, 1'b1);
        chk("R8 write error no dpe", stat_dpe, 1'b0);
        write_status(16'h8100);
    endtask

    task automatic t_resp_off();
        resp_en = 0;
        run_phase(32'h0F0F_0F0F, 4'h1, 1, 1, 1, 1, 1, 0);
        chk("R6 perr_n stays high", perr_n, 1'b1);
        chk("R6 dpd not set", stat_dpd, 1'b0);
        chk("R8 dpe set without enable", stat_dpe, 1'b1);
        write_status(16'h8100);
        resp_en = 1;
    endtask

    task automatic t_not_mine();
        resp_en = 1;
        run_phase(32'h5555_AAAA, 4'h2, 0, 1, 1, 1, 1, 0);
        chk("R3 perr_n", perr_n, 1'b1);
        chk("R3 dpd", stat_dpd, 1'b0);
        chk("R3 dpe", stat_dpe, 1'b0);
    endtask

    task automatic t_not_ready();
        resp_en = 1;
        run_phase(32'h0101_0101, 4'h4, 1, 1, 1, 0, 1, 0);
        chk("R4 target not ready perr_n", perr_n, 1'b1);
        run_phase(32'h0202_0202, 4'h8, 1, 1, 0, 1, 1, 0);
        chk("R4 initiator not ready perr_n", perr_n, 1'b1);
        chk("R4 dpe", stat_dpe, 1'b0);
    endtask

    task automatic t_set_wins();
        resp_en = 1;
        run_phase(32'h7777_0000, 4'h0, 1, 1, 1, 1, 1, 0);
        run_phase(32'h0000_7777, 4'h0, 1, 1, 1, 1, 1, 1);
        chk("R9 set beats clear dpd", stat_dpd, 1'b1);
        chk("R9 set beats clear dpe", stat_dpe, 1'b1);
        write_status(16'h8100);
    endtask

    task automatic t_b2b();
        resp_en = 1;
        @(negedge clk);
        ad_in = 32'hCAFE_0001; be_in = 4'h5; own_xfer = 1; xfer_read = 0;
        init_rdy = 1; tgt_rdy = 1;
        @(negedge clk);
        par_in = ^{32'hCAFE_0001, 4'h5};
        ad_in = 32'hCAFE_0002; be_in = 4'hA;
        @(negedge clk);
        idle_bus();
        par_in = ~(^{32'hCAFE_0002, 4'hA});
        chk("R10 first phase clean", perr_n, 1'b1);
        @(negedge clk);
        idle_bus();
        chk("R10 second phase flagged", perr_n, 1'b0);
        chk("R10 second write no dpe", stat_dpe, 1'b0);
        @(negedge clk);
        chk("R10 pulse ends", perr_n, 1'b1);
        write_status(16'h8100);
    endtask

    initial begin
        #2_000_000;
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_good();
        t_bad_read();
        t_bad_write();
        t_resp_off();
        t_not_mine();
        t_not_ready();
        t_set_wins();
        t_b2b();
        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule